// File: doc/BRIEF.md
# Multiplexer Scan Sequencer with Per-Channel Ranges

This block steers an analog input multiplexer through a window of channels chosen by the host. A one-byte scan-window register holds a start channel and a stop channel. Each of the sixteen channels keeps its own stored setting: a gain code and a polarity bit. The block drives the current channel number and that channel's setting to the analog front end.

The host writes the scan window first, which points the sequencer at the start channel. It then writes a range code, which is stored against that channel. Repeating this for each start value loads every channel's range. Whenever the converter reports that a conversion is finished, the sequencer moves on to the following channel. After the stop channel it returns to the start channel. The window may cross the top of the channel space.

Two status views describe the sequencer. One byte packs the current channel and its setting. A separate nibble gives the channel that the next finished conversion will select. The scan window also reads back unchanged.

Top module: `chan_scan_seq`

## Requirements
- R1: After synchronous reset the current channel is 0, the scan window reads back 8'h00, and every channel holds bipolar polarity with gain code 0.
- R2: A scan write stores `scan_wdata[3:0]` as the start channel and `scan_wdata[7:4]` as the stop channel. From the next cycle the current channel equals the start channel and `scan_rdata` equals the written byte.
- R3: On a conversion-done pulse with no scan write, the current channel advances by one. If the current channel equals the stop channel, it moves to the start channel instead.
- R4: When the start channel is greater than the stop channel, the sequence counts upward, goes from 15 to 0, and continues until it reaches the stop channel.
- R5: A range write stores `range_wdata[2]` as polarity (0 bipolar, 1 unipolar) and `range_wdata[1:0]` as gain against the current channel only. All other channels keep their settings.
- R6: `fe_chan`, `fe_gain` and `fe_unipolar` always present the current channel and that channel's stored setting.
- R7: `cur_cfg` carries the current channel in bits [3:0], the gain in bits [5:4] and the polarity in bit 6. Bit 7 reads 0.
- R8: `next_chan` equals the channel that the next conversion-done pulse would select.
- R9: A scan write in the same cycle as a conversion-done pulse takes precedence. A range write in the same cycle as either event is stored against the channel that was current before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_wr | input | 1 | Scan-window write strobe |
| scan_wdata | input | 8 | Scan window: [3:0] start, [7:4] stop |
| range_wr | input | 1 | Range write strobe for the current channel |
| range_wdata | input | 3 | [2] unipolar, [1:0] gain code |
| conv_done | input | 1 | Conversion-done pulse, advances the channel |
| fe_chan | output | 4 | Channel number to the multiplexer |
| fe_gain | output | 2 | Gain code to the front end |
| fe_unipolar | output | 1 | Polarity to the front end, 1 = unipolar |
| scan_rdata | output | 8 | Scan-window read-back |
| cur_cfg | output | 8 | Current configuration status byte |
| next_chan | output | 4 | Channel to be converted next |

## Verification
The bench builds the block with its default sixteen channels. At this size every one of the 256 start/stop pairs can be swept. Each pair is run for more than a full lap, so both ordinary windows and windows that cross from 15 to 0 are covered, including single-channel windows. Per-channel range storage is loaded one channel at a time and then read back by scanning the whole channel space. Collision cycles between the three write or event strobes are forced deliberately.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;

    localparam int NUM_CH  = 16;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int GAIN_W  = 2;
    localparam int CFG_W   = GAIN_W + 1;
    localparam int BYTE_W  = 8;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        logic              unipolar;
        logic [GAIN_W-1:0] gain;
    } range_cfg_t;

    typedef struct packed {
        chan_t stop;
        chan_t start;
    } scan_win_t;

    localparam range_cfg_t RANGE_RESET = '{unipolar: 1'b0, gain: '0};

    function automatic chan_t chan_inc(input chan_t c);
        if (int'(c) == NUM_CH - 1)
            return '0;
        else
            return c + chan_t'(1);
    endfunction

    function automatic chan_t chan_follow(input chan_t cur, input scan_win_t win);
        if (cur == win.stop)
            return win.start;
        else
            return chan_inc(cur);
    endfunction

endpackage

// File: rtl/scan_window_reg.sv
module scan_window_reg
    import chan_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scan_wr,
    input  scan_win_t scan_wdata,
    input  logic      conv_done,
    output scan_win_t win_q,
    output chan_t     cur_q,
    output chan_t     nxt
);

    chan_t cur_d;

    assign nxt = chan_follow(cur_q, win_q);

    always_comb begin
        cur_d = cur_q;
        if (scan_wr)
            cur_d = scan_wdata.start;
        else if (conv_done)
            cur_d = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cur_q <= '0;
        end else begin
            if (scan_wr)
                win_q <= scan_wdata;
            cur_q <= cur_d;
        end
    end

endmodule

// File: rtl/chan_range_bank.sv
module chan_range_bank
    import chan_scan_pkg::*;
#(
    parameter int DEPTH = NUM_CH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  chan_t      wr_idx,
    input  range_cfg_t wr_cfg,
    input  chan_t      rd_idx,
    output range_cfg_t rd_cfg
);

    range_cfg_t entry_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[i] <= RANGE_RESET;
            else if (wr_en && (int'(wr_idx) == i))
                entry_q[i] <= wr_cfg;
        end
    end

    assign rd_cfg = entry_q[rd_idx];

endmodule

// File: rtl/scan_status_fmt.sv
module scan_status_fmt
    import chan_scan_pkg::*;
(
    input  chan_t             cur,
    input  range_cfg_t        cfg,
    input  scan_win_t         win,
    output logic [BYTE_W-1:0] cfg_byte,
    output logic [BYTE_W-1:0] win_byte
);

    always_comb begin
        cfg_byte = '0;
        cfg_byte[CH_W-1:0]            = cur;
        cfg_byte[CH_W +: GAIN_W]      = cfg.gain;
        cfg_byte[CH_W + GAIN_W]       = cfg.unipolar;
        win_byte = '0;
        win_byte[2*CH_W-1:0]          = win;
    end

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
    import chan_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_wr,
    input  logic [BYTE_W-1:0] scan_wdata,
    input  logic              range_wr,
    input  logic [CFG_W-1:0]  range_wdata,
    input  logic              conv_done,
    output logic [CH_W-1:0]   fe_chan,
    output logic [GAIN_W-1:0] fe_gain,
    output logic              fe_unipolar,
    output logic [BYTE_W-1:0] scan_rdata,
    output logic [BYTE_W-1:0] cur_cfg,
    output logic [CH_W-1:0]   next_chan
);

    scan_win_t  win_q;
    chan_t      cur_q;
    chan_t      nxt;
    range_cfg_t cur_range;

    scan_window_reg u_win (
        .clk        (clk),
        .rst        (rst),
        .scan_wr    (scan_wr),
        .scan_wdata (scan_win_t'(scan_wdata[2*CH_W-1:0])),
        .conv_done  (conv_done),
        .win_q      (win_q),
        .cur_q      (cur_q),
        .nxt        (nxt)
    );

    chan_range_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (range_wr),
        .wr_idx (cur_q),
        .wr_cfg (range_cfg_t'(range_wdata)),
        .rd_idx (cur_q),
        .rd_cfg (cur_range)
    );

    scan_status_fmt u_fmt (
        .cur      (cur_q),
        .cfg      (cur_range),
        .win      (win_q),
        .cfg_byte (cur_cfg),
        .win_byte (scan_rdata)
    );

    assign fe_chan     = cur_q;
    assign fe_gain     = cur_range.gain;
    assign fe_unipolar = cur_range.unipolar;
    assign next_chan   = nxt;

endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk
    import chan_scan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scan_wr,
    input logic [BYTE_W-1:0] scan_wdata,
    input logic              range_wr,
    input logic [CFG_W-1:0]  range_wdata,
    input logic              conv_done,
    input logic [CH_W-1:0]   fe_chan,
    input logic [GAIN_W-1:0] fe_gain,
    input logic              fe_unipolar,
    input logic [BYTE_W-1:0] scan_rdata,
    input logic [BYTE_W-1:0] cur_cfg,
    input logic [CH_W-1:0]   next_chan
);

    a_r2_scan_load: assert property (@(posedge clk) disable iff (rst)
        scan_wr |=> (fe_chan == $past(scan_wdata[CH_W-1:0])) && (scan_rdata == $past(scan_wdata)));

    a_r8_advance_to_next: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !scan_wr) |=> fe_chan == $past(next_chan));

    a_r5_range_store: assert property (@(posedge clk) disable iff (rst)
        (range_wr && !scan_wr && !conv_done) |=>
            (fe_gain == $past(range_wdata[GAIN_W-1:0])) && (fe_unipolar == $past(range_wdata[GAIN_W])));

    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (!range_wr && !scan_wr && !conv_done) |=> $stable(cur_cfg) && $stable(next_chan));

    a_r7_status_agrees: assert property (@(posedge clk) disable iff (rst)
        (cur_cfg[CH_W-1:0] == fe_chan) && (cur_cfg[CH_W +: GAIN_W] == fe_gain)
            && (cur_cfg[CH_W+GAIN_W] == fe_unipolar) && !cur_cfg[BYTE_W-1]);

endmodule

bind chan_scan_seq chan_scan_seq_chk u_chk (.*);

// File: tb/chan_scan_seq_bench.sv
module chan_scan_seq_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       scan_wr;
    logic [7:0] scan_wdata;
    logic       range_wr;
    logic [2:0] range_wdata;
    logic       conv_done;
    logic [3:0] fe_chan;
    logic [1:0] fe_gain;
    logic       fe_unipolar;
    logic [7:0] scan_rdata;
    logic [7:0] cur_cfg;
    logic [3:0] next_chan;

    int n_checks = 0;
    int n_fail   = 0;

    int m_cur, m_start, m_stop;
    int m_cfg [16];

    always #2.5 clk = ~clk;

    chan_scan_seq u_chan_scan_seq (.*);

    function automatic int follow(int c);
        if (c == m_stop) return m_start;
        return (c + 1) % 16;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        int cfgv = m_cfg[m_cur];
        int exp_byte = ((cfgv >> 2) & 1) << 6 | (cfgv & 3) << 4 | m_cur;
        check(fe_chan == 4'(m_cur), req, fe_chan, m_cur);
        check({fe_unipolar, fe_gain} == 3'(cfgv), req, {fe_unipolar, fe_gain}, cfgv);
        check(cur_cfg == 8'(exp_byte), {req, " R7"}, cur_cfg, exp_byte);
        check(next_chan == 4'(follow(m_cur)), {req, " R8"}, next_chan, follow(m_cur));
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        scan_wr = 0; range_wr = 0; conv_done = 0;
    endtask

    task automatic do_scan(input int s, input int e);
        scan_wr = 1; scan_wdata = 8'((e << 4) | s);
        cycle();
        m_start = s; m_stop = e; m_cur = s;
    endtask

    task automatic do_range(input int v);
        range_wr = 1; range_wdata = 3'(v);
        cycle();
        m_cfg[m_cur] = v;
    endtask

    task automatic do_eoc();
        conv_done = 1;
        cycle();
        m_cur = follow(m_cur);
    endtask

    initial begin
        #400000;
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1; scan_wr = 0; scan_wdata = 0; range_wr = 0; range_wdata = 0; conv_done = 0;
        m_cur = 0; m_start = 0; m_stop = 0;
        for (int i = 0; i < 16; i++) m_cfg[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check(scan_rdata == 8'h00, "R1 window", scan_rdata, 0);
        check_outputs("R1");
        // R1: every channel reset to bipolar gain 0, via a full scan
        do_scan(0, 15);
        for (int k = 0; k < 16; k++) begin
            check({fe_unipolar, fe_gain} == 3'b000, "R1 chan cfg", {fe_unipolar, fe_gain}, 0);
            do_eoc();
        end

        // R5: load each channel through the start field
        for (int ch = 0; ch < 16; ch++) begin
            do_scan(ch, ch);
            do_range((ch * 5 + 3) % 8);
            check_outputs("R5 load");
        end
        // R5/R6: read all channels back; other channels untouched
        do_scan(0, 15);
        for (int k = 0; k < 17; k++) begin
            check_outputs("R6 sweep");
            do_eoc();
        end

        // R2/R3/R4: all start/stop pairs
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                do_scan(s, e);
                check(scan_rdata == 8'((e << 4) | s), "R2 readback", scan_rdata, (e << 4) | s);
                check(fe_chan == 4'(s), "R2 start load", fe_chan, s);
                for (int k = 0; k < 18; k++) begin
                    do_eoc();
                    check_outputs(s > e ? "R4 wrap" : "R3 advance");
                end
            end
        end

        // R9: scan write and conversion-done together: scan wins
        do_scan(2, 9);
        do_eoc(); do_eoc();
        scan_wr = 1; scan_wdata = 8'h5C; conv_done = 1;
        cycle();
        m_start = 12; m_stop = 5; m_cur = 12;
        check(fe_chan == 4'd12, "R9 scan over eoc", fe_chan, 12);
        check_outputs("R9");

        // R9: range write with conversion-done: stored to old channel (12)
        range_wr = 1; range_wdata = 3'b110; conv_done = 1;
        cycle();
        m_cfg[12] = 6; m_cur = 13;
        check_outputs("R9 range+eoc");
        // R9: range write with scan write: stored to old channel (13)
        range_wr = 1; range_wdata = 3'b001; scan_wr = 1; scan_wdata = 8'hD3;
        cycle();
        m_cfg[13] = 1; m_start = 3; m_stop = 13; m_cur = 3;
        check_outputs("R9 range+scan");
        do_scan(12, 13);
        check_outputs("R9 verify 12");
        check({fe_unipolar, fe_gain} == 3'b110, "R9 chan12", {fe_unipolar, fe_gain}, 6);
        do_eoc();
        check({fe_unipolar, fe_gain} == 3'b001, "R9 chan13", {fe_unipolar, fe_gain}, 1);
        check_outputs("R9 verify 13");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule